// File: doc/BRIEF.md
# Clock Buffer Control Register Target (block-protocol serial slave)

This block is the control-plane target of a clock fan-out buffer. It sits on a two-wire serial bus (SMBus/I2C signalling) and holds a small bank of byte-wide control registers. From those registers it drives one enable line per differential output pair. A host programs the bank with an indexed block write. It first sends a starting register index, then a byte count, then that many data bytes, which land in consecutive registers. To read, the host sends an index, issues a repeated START and readdresses the target for reading. The target answers with the stored byte count, followed by register contents from the index onward.

SCL and SDA are oversampled by the system clock through a two-flop synchroniser. SDA is driven open-drain through a registered pull-down enable, and all bus decisions are taken on synchronised SCL edges. Reserved bits and reserved bytes are fixed at their power-up values.

Top module: `ckbuf_smb_ctrl`

## Requirements
- R1: After reset every `out_en` bit is 1 and `sda_oe` is 0. Register bytes 0..6 read back as 0xFF, 0xC0, 0xFF, 0xFF, 0xFF, 0xFF and 0xFF, and the byte count register reads 8.
- R2: The target acknowledges only the address bytes 0xD4 (write) and 0xD5 (read), which is 7-bit address 0x6A with the direction in bit 0. Any other address gets no ACK and changes nothing.
- R3: A write follows this order: address, index N, count X, data. Every byte is ACKed (SDA held low during the ninth clock), and data byte k goes to register N+k.
- R4: Only X data bytes are accepted. A further data byte is NACKed and does not change any register. With X = 0, the first data byte is already NACKed.
- R5: Only byte 0 bits 7, 6, 3, 2, 0 and byte 1 bit 6 can be written. Every other bit, including all of bytes 2..6, keeps its reset value.
- R6: `out_en[p]` is 1 (enabled) when its control bit is 1. Pair 0 uses byte 0 bit 7, pair 1 byte 0 bit 6, pair 2 byte 0 bit 3, pair 3 byte 1 bit 6, pair 4 byte 0 bit 0, and pair 5 byte 0 bit 2.
- R7: After the target is readdressed with 0xD5, it sends the count byte and then registers N, N+1, … MSB first. It continues while the host ACKs, and releases SDA after the host NACKs.
- R8: The count byte sent on a read equals the last count the target ACKed during a write.
- R9: A STOP, or a START in the middle of a byte, returns the target to idle. The partial byte is not written, bytes written earlier remain, and any index or count already ACKed is kept.
- R10: For index values of 7 and above, writes are ACKed and discarded, and reads return 0x00.
- R11: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| out_en | output | NPAIRS | Per-pair output enables, 1 = enabled |

## Verification
The bench aims at the byte-count boundary. A target that ignored X would ACK and store a byte past the count. One that counted off by one would NACK the last legal byte or accept one too many. The bench also aborts transfers midway with a STOP and with a START. A design that commits bytes too early would then show a half-received byte in the register, and one that failed to resynchronise would misread the next address. Reads that run past the last real register, and writes with all-zero data, expose a wrong reserved-bit mask or a broken pair-to-bit mapping on `out_en`. A bus monitor flags any change of the SDA drive while SCL is high.

// File: rtl/ckbuf_smb_pkg.sv
package ckbuf_smb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RECV, ST_RXEND, ST_ACK, ST_SEND, ST_HACK, ST_HEND
  } smb_state_t;

  typedef enum logic [1:0] {
    PH_ADDR, PH_INDEX, PH_COUNT, PH_DATA
  } smb_phase_t;

  // power-up value of each register byte
  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      1:       return 8'hC0;
      default: return 8'hFF;
    endcase
  endfunction

  // bits that software may change; everything else is fixed
  function automatic logic [7:0] reg_wmask(input int idx);
    case (idx)
      0:       return 8'hCD;
      1:       return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

  // register byte holding the enable of output pair p
  function automatic int pair_byte(input int p);
    case (p)
      3:       return 1;
      default: return 0;
    endcase
  endfunction

  // bit position of the enable of output pair p
  function automatic int pair_bit(input int p);
    case (p)
      0:       return 7;
      1:       return 6;
      2:       return 3;
      3:       return 6;
      4:       return 0;
      5:       return 2;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_p;
  logic [STAGES-1:0] sda_p;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_q <= scl_p[STAGES-1];
      sda_q <= sda_p[STAGES-1];
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import ckbuf_smb_pkg::*;
#(
  parameter int NREGS  = 7,
  parameter int IDXW   = 8,
  parameter int NPAIRS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDXW-1:0]   idx,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [NPAIRS-1:0] out_en
);

  localparam int FLATW = NREGS * 8;

  logic [NREGS-1:0][7:0] regs;
  logic [FLATW-1:0]      flat;
  logic [NREGS:0][7:0]   rd_chain;
  logic [NPAIRS-1:0]     en_sel;

  assign rd_chain[0] = 8'h00;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    localparam logic [7:0] DEFV = reg_default(g);
    localparam logic [7:0] MSK  = reg_wmask(g);

    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= DEFV;
      end else if (we && idx == IDXW'(g)) begin
        regs[g] <= (regs[g] & ~MSK) | (wdata & MSK);
      end
    end

    assign flat[g*8 +: 8] = regs[g];
    assign rd_chain[g+1]  = rd_chain[g] | ((idx == IDXW'(g)) ? regs[g] : 8'h00);
  end

  assign rdata = rd_chain[NREGS];

  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    localparam int PB   = pair_byte(p);
    localparam int PBIT = pair_bit(p);
    assign en_sel[p] = flat[PB*8 + PBIT];
  end

  always_ff @(posedge clk) begin
    if (rst) out_en <= '1;
    else     out_en <= en_sel;
  end

  // R10: a write aimed past the last register leaves the whole bank untouched
  a_r10_oob_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (we && idx >= IDXW'(NREGS)) |=> $stable(flat));

endmodule

// File: rtl/smb_target_fsm.sv
module smb_target_fsm
  import ckbuf_smb_pkg::*;
#(
  parameter logic [6:0] ADDR7     = 7'h6A,
  parameter int         IDXW      = 8,
  parameter logic [7:0] CNT_RESET = 8'd8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_s,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic [7:0]      rdata,
  output logic            reg_we,
  output logic [IDXW-1:0] reg_idx,
  output logic [7:0]      wdata,
  output logic            sda_oe
);

  smb_state_t      state;
  smb_phase_t      phase;
  logic [2:0]      bitcnt;
  logic [7:0]      shreg;
  logic [7:0]      txsh;
  logic [7:0]      count_q;
  logic [7:0]      remain;
  logic [IDXW-1:0] index;
  logic            rd_mode;
  logic            host_ack;

  assign reg_idx = index;
  assign wdata   = shreg;
  assign reg_we  = (state == ST_RXEND) && scl_fall && !start_det && !stop_det &&
                   (phase == PH_DATA) && (remain != 8'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phase    <= PH_ADDR;
      bitcnt   <= 3'd0;
      shreg    <= 8'h00;
      txsh     <= 8'h00;
      count_q  <= CNT_RESET;
      remain   <= 8'd0;
      index    <= '0;
      rd_mode  <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (start_det) begin
      state  <= ST_RECV;
      phase  <= PH_ADDR;
      bitcnt <= 3'd0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_RECV: if (scl_rise) begin
          shreg <= {shreg[6:0], sda_s};
          if (bitcnt == 3'd7) state <= ST_RXEND;
          else                bitcnt <= bitcnt + 3'd1;
        end
        ST_RXEND: if (scl_fall) begin
          case (phase)
            PH_ADDR: begin
              if (shreg[7:1] == ADDR7) begin
                rd_mode <= shreg[0];
                sda_oe  <= 1'b1;
                state   <= ST_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
            PH_INDEX: begin
              index  <= shreg[IDXW-1:0];
              sda_oe <= 1'b1;
              state  <= ST_ACK;
            end
            PH_COUNT: begin
              count_q <= shreg;
              remain  <= shreg;
              sda_oe  <= 1'b1;
              state   <= ST_ACK;
            end
            default: begin
              if (remain != 8'd0) begin
                index  <= index + 1'b1;
                remain <= remain - 8'd1;
                sda_oe <= 1'b1;
                state  <= ST_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          endcase
        end
        ST_ACK: if (scl_fall) begin
          bitcnt <= 3'd0;
          if (phase == PH_ADDR && rd_mode) begin
            txsh   <= count_q;
            sda_oe <= ~count_q[7];
            state  <= ST_SEND;
          end else begin
            sda_oe <= 1'b0;
            state  <= ST_RECV;
            case (phase)
              PH_ADDR:  phase <= PH_INDEX;
              PH_INDEX: phase <= PH_COUNT;
              default:  phase <= PH_DATA;
            endcase
          end
        end
        ST_SEND: if (scl_fall) begin
          if (bitcnt == 3'd7) begin
            sda_oe <= 1'b0;
            state  <= ST_HACK;
          end else begin
            bitcnt <= bitcnt + 3'd1;
            txsh   <= {txsh[6:0], 1'b0};
            sda_oe <= ~txsh[6];
          end
        end
        ST_HACK: if (scl_rise) begin
          host_ack <= ~sda_s;
          state    <= ST_HEND;
        end
        ST_HEND: if (scl_fall) begin
          if (host_ack) begin
            txsh   <= rdata;
            sda_oe <= ~rdata[7];
            index  <= index + 1'b1;
            bitcnt <= 3'd0;
            state  <= ST_SEND;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  // R11: the pull-down only engages in a cycle that follows a low SCL sample
  a_r11_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_s));

  // R9: a stop condition always leaves the engine idle and the line released
  a_r9_stop_idle: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE && !sda_oe));

  // R7: the engine only transmits after a read-direction address
  a_r7_send_in_read: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEND) |-> rd_mode);

  // R3: every committed data byte advances the index by one
  a_r3_index_steps: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> (index == IDXW'($past(index) + 1'b1)));

endmodule

// File: rtl/ckbuf_smb_ctrl.sv
module ckbuf_smb_ctrl #(
  parameter logic [6:0] ADDR7       = 7'h6A,
  parameter int         NREGS       = 7,
  parameter int         NPAIRS      = 6,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CNT_RESET   = 8'd8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NPAIRS-1:0] out_en
);

  localparam int IDXW = 8;

  logic            scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic            reg_we;
  logic [IDXW-1:0] reg_idx;
  logic [7:0]      wdata, rdata;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_target_fsm #(.ADDR7(ADDR7), .IDXW(IDXW), .CNT_RESET(CNT_RESET)) u_fsm (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rdata(rdata),
    .reg_we(reg_we), .reg_idx(reg_idx), .wdata(wdata), .sda_oe(sda_oe)
  );

  smb_reg_bank #(.NREGS(NREGS), .IDXW(IDXW), .NPAIRS(NPAIRS)) u_bank (
    .clk(clk), .rst(rst), .we(reg_we), .idx(reg_idx), .wdata(wdata),
    .rdata(rdata), .out_en(out_en)
  );

endmodule

// File: tb/sim_ckbuf_smb_ctrl.sv
module sim_ckbuf_smb_ctrl;

  localparam int Q = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       h_sda = 1'b1;
  logic       sda_oe;
  logic [5:0] out_en;
  wire        sda_line = h_sda & ~sda_oe;

  int checks = 0;
  int errors = 0;
  int mon_bad = 0;
  logic prev_oe = 1'b0;

  logic [7:0] mregs [7];
  logic [7:0] mcount;
  logic [7:0] wbuf [8];

  always #10 clk = ~clk;

  ckbuf_smb_ctrl u0 (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .out_en(out_en)
  );

  // R11 monitor: the target's drive must not move while SCL is high
  always @(negedge clk) begin
    if (!rst && sda_oe != prev_oe && scl) mon_bad++;
    prev_oe <= sda_oe;
  end

  function automatic logic [7:0] mask_of(input int i);
    if (i == 0) return 8'hCD;
    if (i == 1) return 8'h40;
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_rd(input int a);
    return (a < 7) ? mregs[a] : 8'h00;
  endfunction

  function automatic logic [5:0] exp_oe();
    return {mregs[0][2], mregs[0][0], mregs[1][6], mregs[0][3], mregs[0][6], mregs[0][7]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    h_sda = 1'b1; wait_q(1);
    scl = 1'b1;   wait_q(1);
    h_sda = 1'b0; wait_q(1);
    scl = 1'b0;   wait_q(1);
  endtask

  task automatic bus_stop();
    h_sda = 1'b0; wait_q(1);
    scl = 1'b1;   wait_q(1);
    h_sda = 1'b1; wait_q(2);
  endtask

  task automatic bit_cycle(input logic b, output logic r);
    h_sda = b;  wait_q(1);
    scl = 1'b1; wait_q(1);
    r = sda_line; wait_q(1);
    scl = 1'b0; wait_q(1);
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], r);
    bit_cycle(1'b1, r);
    ack = ~r;
  endtask

  task automatic read_byte(output logic [7:0] v, input logic hack);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, r);
      v[i] = r;
    end
    bit_cycle(~hack, r);
  endtask

  task automatic do_write(input logic [7:0] idx, input logic [7:0] cnt, input int nsend);
    logic a;
    bus_start();
    write_byte(8'hD4, a); chk(a, "R2 write address ack", a, 1);
    write_byte(idx, a);   chk(a, "R3 index ack", a, 1);
    write_byte(cnt, a);   chk(a, "R3 count ack", a, 1);
    mcount = cnt;
    for (int k = 0; k < nsend; k++) begin
      logic expa;
      expa = (k < cnt);
      write_byte(wbuf[k], a);
      chk(a == expa, expa ? "R3 data ack" : "R4 data beyond count nack", a, expa);
      if (expa && (int'(idx) + k) < 7)
        mregs[int'(idx) + k] = (mregs[int'(idx) + k] & ~mask_of(int'(idx) + k)) |
                               (wbuf[k] & mask_of(int'(idx) + k));
      if (!a) break;
    end
    bus_stop();
    wait_q(1);
    chk(out_en == exp_oe(), "R6 output enables", out_en, exp_oe());
  endtask

  task automatic do_read(input logic [7:0] idx, input int n, input string tag);
    logic a;
    logic [7:0] v;
    bus_start();
    write_byte(8'hD4, a); chk(a, "R2 write address ack", a, 1);
    write_byte(idx, a);   chk(a, "R3 index ack", a, 1);
    bus_start();
    write_byte(8'hD5, a); chk(a, "R2 read address ack", a, 1);
    read_byte(v, 1'b1);   chk(v == mcount, "R8 count byte", v, mcount);
    for (int k = 0; k < n; k++) begin
      read_byte(v, k != n - 1);
      chk(v == exp_rd(int'(idx) + k), tag, v, exp_rd(int'(idx) + k));
    end
    chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    logic r;
    logic [7:0] v;
    void'($urandom(32'h5EED_0C1C));
    for (int i = 0; i < 7; i++) mregs[i] = (i == 1) ? 8'hC0 : 8'hFF;
    mcount = 8'd8;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    wait_q(1);

    // R1 reset state at the ports and through a full read
    chk(out_en == 6'h3F, "R1 reset enables", out_en, 6'h3F);
    chk(sda_oe == 1'b0, "R1 reset sda drive", sda_oe, 0);
    do_read(8'd0, 7, "R1 default byte");

    // R2 foreign address: no ack, nothing changes
    bus_start();
    write_byte(8'hA8, a); chk(!a, "R2 foreign address nack", a, 0);
    for (int k = 0; k < 3; k++) begin
      write_byte(8'h00, a); chk(!a, "R2 idle after foreign address", a, 0);
    end
    bus_stop();
    chk(out_en == exp_oe(), "R2 enables unchanged", out_en, exp_oe());

    // R5 / R6 zero everything writable, including reserved bytes
    for (int k = 0; k < 8; k++) wbuf[k] = 8'h00;
    do_write(8'd0, 8'd7, 7);
    chk(out_en == 6'h00, "R6 all pairs disabled", out_en, 6'h00);
    do_read(8'd0, 7, "R5 masked readback");

    // R6 single pair enables, one at a time
    for (int p = 0; p < 6; p++) begin
      wbuf[0] = (p == 0) ? 8'h80 : (p == 1) ? 8'h40 : (p == 2) ? 8'h08 :
                (p == 4) ? 8'h01 : (p == 5) ? 8'h04 : 8'h00;
      wbuf[1] = (p == 3) ? 8'h40 : 8'h00;
      do_write(8'd0, 8'd2, 2);
      chk(out_en == (6'd1 << p), "R6 single pair", out_en, 6'd1 << p);
    end

    // R4 byte past the count and a zero count
    wbuf[0] = 8'hFF; wbuf[1] = 8'hFF; wbuf[2] = 8'h00;
    do_write(8'd0, 8'd2, 3);
    do_read(8'd0, 2, "R4 bytes within count");
    do_write(8'd0, 8'd0, 1);
    do_read(8'd0, 1, "R4 zero count no write");

    // R10 out of range writes and reads
    wbuf[0] = 8'h00;
    do_write(8'd7, 8'd1, 1);
    do_read(8'd5, 4, "R10 out of range read");

    // R9 stop in the middle of a data byte
    bus_start();
    write_byte(8'hD4, a); write_byte(8'd0, a); write_byte(8'd2, a);
    mcount = 8'd2;
    write_byte(8'h00, a);
    mregs[0] = mregs[0] & ~mask_of(0);
    for (int i = 0; i < 4; i++) bit_cycle(1'b0, r);
    bus_stop();
    do_read(8'd0, 2, "R9 partial byte after stop");

    // R9 start in the middle of a data byte, then read from the kept index
    bus_start();
    write_byte(8'hD4, a); write_byte(8'd1, a); write_byte(8'd1, a);
    mcount = 8'd1;
    for (int i = 0; i < 4; i++) bit_cycle(1'b0, r);
    bus_start();
    write_byte(8'hD5, a); chk(a, "R9 readdress after abort", a, 1);
    read_byte(v, 1'b1);   chk(v == mcount, "R9 count kept", v, mcount);
    read_byte(v, 1'b0);   chk(v == mregs[1], "R9 byte1 unchanged", v, mregs[1]);
    bus_stop();

    // R3 / R7 random block writes and reads
    for (int it = 0; it < 14; it++) begin
      logic [7:0] idx;
      logic [7:0] cnt;
      idx = 8'($urandom_range(0, 8));
      cnt = 8'($urandom_range(0, 4));
      for (int k = 0; k < 8; k++) wbuf[k] = 8'($urandom());
      do_write(idx, cnt, int'(cnt));
      do_read(8'($urandom_range(0, 7)), int'($urandom_range(1, 4)), "R7 random read");
    end

    chk(mon_bad == 0, "R11 sda drive moved while scl high", mon_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule